// File: doc/BRIEF.md
# Key-Protected Interrupt Grouping and Reset Command Register

This block is one 32-bit control register inside a processor's system controller. Software reaches it through a plain register bus made of a decoded select, a write enable and 32-bit write and read data. Every write is screened by an unlock key carried in the upper halfword. A write without the exact key is thrown away whole: no field changes and no command fires.

The register holds a 3-bit priority grouping value. From it the block derives an 8-bit pre-emption mask, which tells the interrupt logic which upper bits of an 8-bit priority take part in pre-emption. Three command bits drive the outputs to the rest of the system. The first is a sticky system reset request, which stays set until the warm reset it triggers clears it. The second is a one-cycle pulse that clears the active exception state. The third is a one-cycle local reset pulse that leaves debug logic untouched.

The read path does not echo the key. It returns a fixed status word, the key with its bytes swapped, in the upper halfword. It also reports little-endian operation and returns zero in every reserved bit.

Top module: `irc_top`

## Requirements
- R1: A write (regSel=1, regWe=1) changes state or fires a command only when regWdata[31:16] equals 0x05FA. A write with any other key, or a select without regWe, leaves every field and output unchanged.
- R2: While regSel=1, regRdata[31:16] reads 0xFA05 whatever was written. Bit 15 (endianness, 0 = little-endian) reads 0. Reserved bits 14:11 and 7:3 read 0 and ignore written ones.
- R3: A keyed write stores regWdata[10:8] as the grouping value g, which reads back in bits 10:8. preemptMask has bit i set exactly when i > g: 0xFE for g=0, and the set bits shrink down to 0x00 for g=7.
- R4: A keyed write with bit 2 set raises sysResetReq from the next clock edge, and it reads back as 1 in bit 2. Later keyed writes with bit 2 clear do not lower it.
- R5: A keyed write with bit 1 set makes clearActive high for exactly one clock cycle after the write edge. Bit 1 reads 0 afterwards.
- R6: A keyed write with bit 0 set makes localReset high for exactly one clock cycle after the write edge. Bit 0 reads 0 afterwards.
- R7: After power-on reset (porRstN low), g=0, preemptMask=0xFE, all three command outputs are 0, and a read returns 0xFA050000.
- R8: Asserting warmRstN low clears sysResetReq and the grouping value at once, without waiting for a clock edge.
- R9: While regSel=0, regRdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, clears all state |
| warmRstN | input | 1 | Warm reset, active low, clears the request bit and grouping value |
| regSel | input | 1 | Register selected by the address decode |
| regWe | input | 1 | Write enable, qualified by regSel |
| regWdata | input | 32 | Write data; key in bits 31:16 |
| regRdata | output | 32 | Read data, valid while regSel=1 |
| preemptMask | output | 8 | Priority bits that take part in pre-emption |
| sysResetReq | output | 1 | Sticky system reset request |
| clearActive | output | 1 | One-cycle clear of active exception state |
| localReset | output | 1 | One-cycle local reset, debug excluded |

## Verification
The bench sends near-miss keys that differ from 0x05FA in one byte, and keyed selects with write enable low. A design with a loose key compare would let the grouping value or a command pulse leak through. It walks all eight grouping values, including g=7 where the mask must be empty, so an off-by-one mask would show as one extra or one missing bit at either end. It measures each command pulse over two consecutive samples to catch a bit that sticks or one that never fires. It also writes zeros after a reset request to catch a request that a plain write wrongly clears. Warm reset is checked before any clock edge follows, to catch a synchronous clear where an immediate one is required.

// File: rtl/irc_pkg.sv
package irc_pkg;
  // Unlock key accepted on writes and status word returned on reads
  localparam logic [15:0] KEY_WRITE = 16'h05FA;
  localparam logic [15:0] KEY_READ  = 16'hFA05;

  // Bit positions software relies on
  localparam int GROUP_LSB = 8;
  localparam int REQ_BIT   = 2;
  localparam int CLR_BIT   = 1;
  localparam int RST_BIT   = 0;

  typedef struct packed {
    logic wrGroup;   // keyed write: load grouping value
    logic setReq;    // keyed write with request bit
    logic pulseClr;  // keyed write with clear-active bit
    logic pulseRst;  // keyed write with local-reset bit
  } ircStrobes_t;
endpackage

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16
) (
  input  logic              regSel,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output ircStrobes_t       strobes
);
  localparam int KEY_MSB = DATA_W - 1;

  logic keyOk;
  logic accept;

  // R1: only the exact key in the upper halfword unlocks a write
  assign keyOk  = (regWdata[KEY_MSB -: KEY_W] == KEY_WRITE);
  assign accept = regSel && regWe && keyOk;

  always_comb begin
    strobes          = '0;
    strobes.wrGroup  = accept;
    strobes.setReq   = accept && regWdata[REQ_BIT];
    strobes.pulseClr = accept && regWdata[CLR_BIT];
    strobes.pulseRst = accept && regWdata[RST_BIT];
  end
endmodule

// File: rtl/irc_mask_gen.sv
module irc_mask_gen #(
  parameter int GROUP_W = 3,
  parameter int PRIO_W  = 8
) (
  input  logic [GROUP_W-1:0] groupIn,
  output logic [PRIO_W-1:0]  preemptMask
);
  localparam int CMP_W = GROUP_W + 1;

  // R3: bit i belongs to pre-emption when it sits above the grouping point
  for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
    localparam logic [CMP_W-1:0] IDX = CMP_W'(i);
    assign preemptMask[i] = (IDX > {1'b0, groupIn});
  end

  always_comb begin
    if (!$isunknown(groupIn)) begin
      a_r3_mask_width: assert ($countones(preemptMask) + int'(groupIn) == PRIO_W - 1)
        else $error("R3 mask width does not match grouping value");
      a_r3_mask_lsb_clear: assert (preemptMask[0] == 1'b0)
        else $error("R3 mask bit 0 set");
    end
  end
endmodule

// File: rtl/irc_datapath.sv
module irc_datapath
  import irc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 3,
  parameter int KEY_W   = 16
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               warmRstN,
  input  ircStrobes_t        strobes,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [GROUP_W-1:0] groupQ,
  output logic               sysResetReq,
  output logic               clearActive,
  output logic               localReset,
  output logic [DATA_W-1:0]  regRdata
);
  localparam int KEY_MSB = DATA_W - 1;

  logic reqQ;
  logic clrQ;
  logic rstQ;

  // R3, R4, R8: state that warm reset also clears
  always_ff @(posedge clk or negedge porRstN or negedge warmRstN) begin
    if (!porRstN || !warmRstN) begin
      groupQ <= '0;
      reqQ   <= 1'b0;
    end else begin
      if (strobes.wrGroup) groupQ <= regWdata[GROUP_LSB +: GROUP_W];
      if (strobes.setReq)  reqQ   <= 1'b1;
    end
  end

  // R5, R6: single-cycle command pulses
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      clrQ <= 1'b0;
      rstQ <= 1'b0;
    end else begin
      clrQ <= strobes.pulseClr;
      rstQ <= strobes.pulseRst;
    end
  end

  assign sysResetReq = reqQ;
  assign clearActive = clrQ;
  assign localReset  = rstQ;

  // R2, R9: read word with status key, zero endianness and reserved bits
  always_comb begin
    regRdata = '0;
    if (regSel) begin
      regRdata[KEY_MSB -: KEY_W]        = KEY_READ;
      regRdata[GROUP_LSB +: GROUP_W]    = groupQ;
      regRdata[REQ_BIT]                 = reqQ;
      regRdata[CLR_BIT]                 = clrQ;
      regRdata[RST_BIT]                 = rstQ;
    end
  end

  a_r1_group_held: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    !strobes.wrGroup |=> $stable(groupQ))
    else $error("R1 grouping changed without keyed write");

  a_r4_req_set: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    strobes.setReq |=> reqQ)
    else $error("R4 request not raised");

  a_r4_req_sticky: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    reqQ |=> reqQ)
    else $error("R4 request dropped without warm reset");

  a_r5_clr_single: assert property (@(posedge clk) disable iff (!porRstN)
    (clrQ && !strobes.pulseClr) |=> !clrQ)
    else $error("R5 clear pulse longer than one cycle");

  a_r6_rst_single: assert property (@(posedge clk) disable iff (!porRstN)
    (rstQ && !strobes.pulseRst) |=> !rstQ)
    else $error("R6 local reset pulse longer than one cycle");

  a_r2_status_key: assert property (@(posedge clk) disable iff (!porRstN)
    regSel |-> (regRdata[KEY_MSB -: KEY_W] == KEY_READ && regRdata[15:11] == '0 && regRdata[7:3] == '0))
    else $error("R2 read status word wrong");
endmodule

// File: rtl/irc_top.sv
module irc_top
  import irc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 3,
  parameter int PRIO_W  = 8,
  parameter int KEY_W   = 16
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              warmRstN,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [PRIO_W-1:0] preemptMask,
  output logic              sysResetReq,
  output logic              clearActive,
  output logic              localReset
);
  ircStrobes_t        strobes;
  logic [GROUP_W-1:0] groupQ;

  irc_ctrl #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_ctrl (
    .regSel   (regSel),
    .regWe    (regWe),
    .regWdata (regWdata),
    .strobes  (strobes)
  );

  irc_datapath #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .KEY_W(KEY_W)) u_dp (
    .clk         (clk),
    .porRstN     (porRstN),
    .warmRstN    (warmRstN),
    .strobes     (strobes),
    .regSel      (regSel),
    .regWdata    (regWdata),
    .groupQ      (groupQ),
    .sysResetReq (sysResetReq),
    .clearActive (clearActive),
    .localReset  (localReset),
    .regRdata    (regRdata)
  );

  irc_mask_gen #(.GROUP_W(GROUP_W), .PRIO_W(PRIO_W)) u_mask (
    .groupIn     (groupQ),
    .preemptMask (preemptMask)
  );
endmodule

// File: tb/irc_top_tb.sv
module irc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        warmRstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  preemptMask;
  logic        sysResetReq;
  logic        clearActive;
  logic        localReset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  irc_top u_dut (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN),
    .regSel(regSel), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .preemptMask(preemptMask),
    .sysResetReq(sysResetReq), .clearActive(clearActive), .localReset(localReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic we);
    @(negedge clk);
    regSel = 1'b1; regWe = we; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWe = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(output logic [31:0] r);
    regSel = 1'b1; regWe = 1'b0;
    #1 r = regRdata;
    regSel = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] expMask(input int g);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) m[i] = (i > g);
    return m;
  endfunction

  task automatic testResetState();
    logic [31:0] r;
    readReg(r);
    check(r == 32'hFA050000, "R7 reset readback", r, 32'hFA050000);
    check(preemptMask == 8'hFE, "R7 reset mask", {24'h0, preemptMask}, 32'hFE);
    check({sysResetReq, clearActive, localReset} == 3'b000, "R7 reset outputs",
          {29'h0, sysResetReq, clearActive, localReset}, 32'h0);
    check(regRdata == 32'h0, "R9 idle read zero", regRdata, 32'h0);
  endtask

  task automatic testKeyReject();
    logic [31:0] r;
    doWrite(32'h05FA_0300, 1'b1);            // g=3 accepted
    doWrite(32'h05FB_0707, 1'b1);            // low key byte off
    check({clearActive, localReset} == 2'b00, "R1 bad key no pulse",
          {30'h0, clearActive, localReset}, 32'h0);
    doWrite(32'h04FA_0607, 1'b1);            // high key byte off
    doWrite(32'hFA05_0507, 1'b1);            // read status used as key
    doWrite(32'h05FA_0107, 1'b0);            // key right, no write enable
    check({clearActive, localReset} == 2'b00, "R1 no-we no pulse",
          {30'h0, clearActive, localReset}, 32'h0);
    readReg(r);
    check(r == 32'hFA050300, "R1 rejected writes leave g=3", r, 32'hFA050300);
    check(sysResetReq == 1'b0, "R1 rejected writes no request", {31'h0, sysResetReq}, 32'h0);
  endtask

  task automatic testGroupSweep();
    logic [31:0] r;
    for (int g = 0; g < 8; g++) begin
      doWrite(32'h05FA_0000 | (32'(g) << 8), 1'b1);
      readReg(r);
      check(r[10:8] == 3'(g), "R3 group readback", r, 32'hFA050000 | (32'(g) << 8));
      check(preemptMask == expMask(g), "R3 preempt mask", {24'h0, preemptMask}, {24'h0, expMask(g)});
    end
  endtask

  task automatic testReservedBits();
    logic [31:0] r;
    doWrite(32'h05FA_FDF8, 1'b1);            // all reserved ones, endian 1, g=5
    readReg(r);
    check(r == 32'hFA050500, "R2 reserved and endianness read 0", r, 32'hFA050500);
  endtask

  task automatic testClearPulse();
    logic [31:0] r;
    doWrite(32'h05FA_0502, 1'b1);
    check(clearActive == 1'b1, "R5 clear pulse high", {31'h0, clearActive}, 32'h1);
    check(localReset == 1'b0, "R6 no local reset on clear", {31'h0, localReset}, 32'h0);
    @(negedge clk);
    check(clearActive == 1'b0, "R5 clear pulse one cycle", {31'h0, clearActive}, 32'h0);
    readReg(r);
    check(r[1] == 1'b0, "R5 clear bit self-clears", r, 32'hFA050500);
  endtask

  task automatic testLocalReset();
    logic [31:0] r;
    doWrite(32'h05FA_0501, 1'b1);
    check(localReset == 1'b1, "R6 local reset high", {31'h0, localReset}, 32'h1);
    check(clearActive == 1'b0, "R5 no clear on local reset", {31'h0, clearActive}, 32'h0);
    @(negedge clk);
    check(localReset == 1'b0, "R6 local reset one cycle", {31'h0, localReset}, 32'h0);
    readReg(r);
    check(r[0] == 1'b0, "R6 reset bit self-clears", r, 32'hFA050500);
  endtask

  task automatic testRequestAndWarm();
    logic [31:0] r;
    doWrite(32'h05FA_0604, 1'b1);
    check(sysResetReq == 1'b1, "R4 request raised", {31'h0, sysResetReq}, 32'h1);
    repeat (3) @(negedge clk);
    doWrite(32'h05FA_0600, 1'b1);
    check(sysResetReq == 1'b1, "R4 request sticky", {31'h0, sysResetReq}, 32'h1);
    readReg(r);
    check(r == 32'hFA050604, "R4 request readback", r, 32'hFA050604);
    @(negedge clk);
    warmRstN = 1'b0;
    #1;
    check(sysResetReq == 1'b0, "R8 warm clears request", {31'h0, sysResetReq}, 32'h0);
    check(preemptMask == 8'hFE, "R8 warm clears grouping", {24'h0, preemptMask}, 32'hFE);
    @(negedge clk);
    warmRstN = 1'b1;
    readReg(r);
    check(r == 32'hFA050000, "R8 readback after warm", r, 32'hFA050000);
  endtask

  task automatic testPowerOn();
    logic [31:0] r;
    doWrite(32'h05FA_0704, 1'b1);
    @(negedge clk);
    porRstN = 1'b0;
    #1;
    readReg(r);
    check(r == 32'hFA050000, "R7 power-on clears all", r, 32'hFA050000);
    check(sysResetReq == 1'b0, "R7 power-on clears request", {31'h0, sysResetReq}, 32'h0);
    @(negedge clk);
    porRstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    warmRstN = 1'b1;
    @(negedge clk);
    testResetState();
    testKeyReject();
    testGroupSweep();
    testReservedBits();
    testClearPulse();
    testLocalReset();
    testRequestAndWarm();
    testPowerOn();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule